// File: doc/BRIEF.md
# Eight-Digit Operand Display Scanner

This block drives a bank of eight seven-segment digits that share one segment bus and one 3-bit digit select. It shows four 8-bit operands of a division (remainder, quotient, divisor, dividend) as two decimal digits each. A one-cycle scan tick moves it to the next digit position. For each position it takes the matching operand, converts it to decimal, picks the units or the tens digit, and encodes that digit into segment lines.

The digit select and the segment pattern are registered together. A new position and its pattern therefore always appear on the same clock edge. When no tick arrives, the current position is held. Its pattern is still refreshed every cycle, so a change on an operand shows up one cycle later.

Top module: `opdisp_scan`

## Requirements
- R1: While `rst_n` is low, `dig_sel` is 0 and `seg` is 0000000 (all segments off) one clock edge later. After reset is released, the first edge shows the digit for position 0.
- R2: `dig_sel` advances by exactly one on each clock edge where `scan_tick` is high. It keeps its value on every edge where `scan_tick` is low.
- R3: After position 7, `dig_sel` wraps to 0.
- R4: The positions map to digits as follows. 0 is remainder units and 1 is remainder tens. 2 is quotient units and 3 is quotient tens. 4 is divisor units and 5 is divisor tens. 6 is dividend units and 7 is dividend tens.
- R5: `seg` is active-high, with bit 6 driving segment a and bit 0 driving segment g. The codes are 0=1111110, 1=0110000, 2=1101101, 3=1111001, 4=0110011, 5=1011011, 6=1011111, 7=1110000, 8=1111111 and 9=1111011.
- R6: An operand of 100 or more shows only its two lowest decimal digits. The hundreds digit is dropped.
- R7: `seg` always shows the digit for the position currently on `dig_sel`. Both outputs change on the same edge. `seg` reflects the operand values sampled at that edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous reset, active low |
| scan_tick | input | 1 | Advance to the next digit position |
| rem_val | input | OPW | Remainder operand |
| quo_val | input | OPW | Quotient operand |
| dvs_val | input | OPW | Divisor operand |
| dvd_val | input | OPW | Dividend operand |
| seg | output | 7 | Segment lines a..g, active high |
| dig_sel | output | 3 | Index of the lit digit |

## Verification
The bench builds the block with the default OPW of 8. With that width, every operand from 0 to 255 is reachable, including the range 100 to 255 where the hundreds digit must be dropped. Random ticks and operand changes are mixed with runs of eight consecutive ticks, so the bench covers the full cycle of positions and the wrap from 7 to 0. Directed values 0, 9, 10, 99, 100 and 255 cover the digit boundaries, and a reset in mid-scan covers the blanking and the restart at position 0.

// File: rtl/opdisp_scan.sv
module opdisp_scan #(
  parameter int OPW = 8
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic           scan_tick,
  input  logic [OPW-1:0] rem_val,
  input  logic [OPW-1:0] quo_val,
  input  logic [OPW-1:0] dvs_val,
  input  logic [OPW-1:0] dvd_val,
  output logic [6:0]     seg,
  output logic [2:0]     dig_sel
);

  localparam int NDIG_RAW = (OPW * 302 + 999) / 1000;
  localparam int NDIG     = (NDIG_RAW < 2) ? 2 : NDIG_RAW;
  localparam int BW       = 4 * NDIG;

  function automatic logic [7:0] low_two_bcd(input logic [OPW-1:0] v);
    logic [BW-1:0] b;
    b = '0;
    for (int i = OPW - 1; i >= 0; i--) begin
      for (int d = 0; d < NDIG; d++) begin
        if (b[4*d +: 4] > 4'd4) b[4*d +: 4] = b[4*d +: 4] + 4'd3;
      end
      b = {b[BW-2:0], v[i]};
    end
    return b[7:0];
  endfunction

  function automatic logic [6:0] encode(input logic [3:0] n);
    case (n)
      4'd0:    return 7'b1111110;
      4'd1:    return 7'b0110000;
      4'd2:    return 7'b1101101;
      4'd3:    return 7'b1111001;
      4'd4:    return 7'b0110011;
      4'd5:    return 7'b1011011;
      4'd6:    return 7'b1011111;
      4'd7:    return 7'b1110000;
      4'd8:    return 7'b1111111;
      4'd9:    return 7'b1111011;
      default: return 7'b0000000;
    endcase
  endfunction

  logic [2:0]     slot_nxt;
  logic [OPW-1:0] operand;
  logic [7:0]     bcd;
  logic [3:0]     nib;

  assign slot_nxt = scan_tick ? dig_sel + 3'd1 : dig_sel;

  always_comb begin
    case (slot_nxt[2:1])
      2'd0:    operand = rem_val;
      2'd1:    operand = quo_val;
      2'd2:    operand = dvs_val;
      default: operand = dvd_val;
    endcase
  end

  assign bcd = low_two_bcd(operand);
  assign nib = slot_nxt[0] ? bcd[7:4] : bcd[3:0];

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      dig_sel <= 3'd0;
      seg     <= 7'd0;
    end else begin
      dig_sel <= slot_nxt;
      seg     <= encode(nib);
    end
  end

endmodule

// File: rtl/opdisp_scan_chk.sv
module opdisp_scan_chk #(
  parameter int OPW = 8
) (
  input logic           clk,
  input logic           rst_n,
  input logic           scan_tick,
  input logic [6:0]     seg,
  input logic [2:0]     dig_sel
);

  a_r1_reset_blank: assert property (@(posedge clk)
    !rst_n |=> (seg == 7'd0 && dig_sel == 3'd0));

  a_r2_hold: assert property (@(posedge clk) disable iff (!rst_n)
    (rst_n && !scan_tick) |=> $stable(dig_sel));

  a_r3_step_wrap: assert property (@(posedge clk) disable iff (!rst_n)
    (rst_n && scan_tick) |=> dig_sel == 3'($past(dig_sel) + 3'd1));

  a_r5_lit_digit: assert property (@(posedge clk) disable iff (!rst_n)
    $past(rst_n) |-> $countones(seg) >= 2);

endmodule

bind opdisp_scan opdisp_scan_chk #(.OPW(OPW)) u_chk (
  .clk(clk), .rst_n(rst_n), .scan_tick(scan_tick), .seg(seg), .dig_sel(dig_sel)
);

// File: tb/test_opdisp_scan.sv
module test_opdisp_scan;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       scan_tick = 1'b0;
  logic [7:0] rem_val = 8'd0, quo_val = 8'd0, dvs_val = 8'd0, dvd_val = 8'd0;
  logic [6:0] seg;
  logic [2:0] dig_sel;

  int checks = 0, failures = 0;
  int eslot = 0;
  bit done = 0;

  always #2 clk = ~clk;

  opdisp_scan #(.OPW(8)) i_opdisp_scan (
    .clk(clk), .rst_n(rst_n), .scan_tick(scan_tick),
    .rem_val(rem_val), .quo_val(quo_val), .dvs_val(dvs_val), .dvd_val(dvd_val),
    .seg(seg), .dig_sel(dig_sel)
  );

  function automatic logic [6:0] ref_code(input int d);
    case (d)
      0: return 7'b1111110;  1: return 7'b0110000;
      2: return 7'b1101101;  3: return 7'b1111001;
      4: return 7'b0110011;  5: return 7'b1011011;
      6: return 7'b1011111;  7: return 7'b1110000;
      8: return 7'b1111111;  9: return 7'b1111011;
      default: return 7'b0000000;
    endcase
  endfunction

  function automatic logic [6:0] ref_seg(input int s);
    int v;
    case (s / 2)
      0: v = rem_val;
      1: v = quo_val;
      2: v = dvs_val;
      default: v = dvd_val;
    endcase
    return ref_code((s % 2 == 1) ? (v / 10) % 10 : v % 10);
  endfunction

  task automatic chk(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      failures++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic step(input string req);
    @(posedge clk);
    if (!rst_n) eslot = 0;
    else if (scan_tick) eslot = (eslot + 1) % 8;
    @(negedge clk);
    if (!rst_n) begin
      chk("R1 sel", dig_sel, 0);
      chk("R1 seg", seg, 0);
    end else begin
      chk({req, " sel"}, dig_sel, eslot);
      chk({req, " seg"}, seg, ref_seg(eslot));
    end
  endtask

  task automatic set_ops(input int a, input int b, input int c, input int d);
    rem_val = 8'(a); quo_val = 8'(b); dvs_val = 8'(c); dvd_val = 8'(d);
  endtask

  initial begin
    #400000;
    if (!done) begin
      failures++;
      checks++;
      $display("FAIL watchdog actual=hung expected=done");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin
    void'($urandom(1234));
    @(negedge clk);
    step("R1");
    step("R1");
    rst_n = 1'b1;
    set_ops(37, 81, 9, 10);
    step("R7 first");
    // R2: hold without tick
    for (int k = 0; k < 3; k++) step("R2 hold");
    // R4 R5 R3: full cycle and wrap
    scan_tick = 1'b1;
    for (int k = 0; k < 9; k++) step("R4 R3 scan");
    // R6 and digit boundaries
    set_ops(255, 100, 99, 0);
    for (int k = 0; k < 8; k++) step("R6 boundary");
    set_ops(123, 246, 10, 9);
    for (int k = 0; k < 8; k++) step("R6 boundary");
    // R5: every digit on position 0
    scan_tick = 1'b0;
    while (dig_sel != 3'd0) begin scan_tick = 1'b1; step("R3"); end
    scan_tick = 1'b0;
    for (int d = 0; d < 10; d++) begin
      rem_val = 8'(d * 11);
      step("R5 code");
    end
    // R7: operand change without tick appears one cycle later
    rem_val = 8'd42;
    step("R7 refresh");
    // random mix
    for (int k = 0; k < 3000; k++) begin
      scan_tick = 1'($urandom_range(0, 2) == 0);
      if ($urandom_range(0, 3) == 0)
        set_ops($urandom_range(0, 255), $urandom_range(0, 255),
                $urandom_range(0, 255), $urandom_range(0, 255));
      if (k == 1500) rst_n = 1'b0;
      if (k == 1502) rst_n = 1'b1;
      step("R2 R7 random");
    end
    done = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule